// File: doc/BRIEF.md
# SDRAM Activate Spacing Timer

This block sits beside the command scheduler of an SDRAM controller and decides, cycle by cycle, whether an activate command may be sent to each bank. The scheduler reports every command it has just issued on a set of single-cycle strobes. The strobes cover auto refresh, leaving self-refresh, loading the mode register, and activate, which comes with a bank index. The block holds a separate minimum-spacing interval for each of these predecessor events. It drives a per-bank permission vector that stays low until every interval that applies has run out.

Each interval is programmed as a code in a small register field, and the code gives a count of code plus one clock cycles. Because of this, an all-ones code in a field gives a power-of-two count. Each interval runs on its own down-counter. A triggering strobe loads the counter with the current code plus one. The count then runs down to zero no matter what is written to the register meanwhile. The activate-to-activate spacing applies only between different banks. A second activate to the bank that was last activated is never held back by that interval.

The strobes and the permission vector are plain level signals with no valid/ready handshake. The block never applies back-pressure: a strobe is always taken in the cycle it is high, and the scheduler is expected to consult the permission vector before it issues an activate. The register port is a simple write-enable port with a combinational read of the addressed field.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: After reset the four fields read back as 7 (address 0, refresh-to-activate), 9 (address 1, self-refresh-exit-to-activate), 1 (address 2, activate-to-activate across banks) and 0 (address 3, mode-load-to-activate).
- R2: Addresses 0 and 1 hold 5-bit fields in bits 4:0, and addresses 2 and 3 hold 4-bit fields in bits 3:0. Bits above a field read as zero, and writing ones to them changes nothing.
- R3: After an auto refresh strobe is sampled, every bit of the permission vector is low for exactly (address 0 code + 1) cycles and then returns high, when no other interval is running.
- R4: After a self-refresh exit strobe, every bank is blocked for exactly (address 1 code + 1) cycles.
- R5: After a mode-load strobe, every bank is blocked for exactly (address 3 code + 1) cycles, so code 0 blocks for a single cycle.
- R6: An all-ones code gives a power-of-two count: 31 gives 32 cycles in the 5-bit fields, and 15 gives 16 cycles in the 4-bit fields.
- R7: After an activate to bank b, every other bank is blocked for exactly (address 2 code + 1) cycles, while bank b itself stays allowed.
- R8: A bank is allowed only when every interval that applies to it has expired. When intervals overlap, the longest one sets the release, and right after reset all banks are allowed.
- R9: Writing a field while its interval is counting does not change the count in progress. The new code takes effect at the next triggering strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed field, zero-extended |
| cmd_refresh | input | 1 | Auto refresh issued this cycle |
| cmd_sr_exit | input | 1 | Self-refresh exit issued this cycle |
| cmd_mode_load | input | 1 | Mode register load issued this cycle |
| cmd_act | input | 1 | Activate issued this cycle |
| cmd_act_bank | input | 2 | Bank index of the activate |
| act_allowed | output | 4 | Per-bank activate permission |

## Verification
On every cycle the assertions check the following: a triggering strobe loads its counter with the sampled code plus one, and a running counter falls by exactly one whatever the register port does. Every bank is low in the cycle after a refresh, self-refresh exit or mode load. After an activate, the activated bank stays allowed and all the other banks are blocked. Only the bench scenarios can show the full length of each blocked window and the release point when intervals overlap. They also show the reset values, the reserved bits, and that the new code applies only from the next strobe.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int REF_W   = 5;
  localparam int SRX_W   = 5;
  localparam int RRD_W   = 4;
  localparam int MRD_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REF = 2'd0,
    SEL_SRX = 2'd1,
    SEL_RRD = 2'd2,
    SEL_MRD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [REF_W-1:0] ref_code;
    logic [SRX_W-1:0] srx_code;
    logic [RRD_W-1:0] rrd_code;
    logic [MRD_W-1:0] mrd_code;
  } timing_cfg_t;

  localparam logic [REF_W-1:0] REF_RST = REF_W'(7);
  localparam logic [SRX_W-1:0] SRX_RST = SRX_W'(9);
  localparam logic [RRD_W-1:0] RRD_RST = RRD_W'(1);
  localparam logic [MRD_W-1:0] MRD_RST = MRD_W'(0);
endpackage

// File: rtl/sdt_regs.sv
module sdt_regs
  import sdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output timing_cfg_t       cfg
);
  timing_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.ref_code <= REF_RST;
      cfg_q.srx_code <= SRX_RST;
      cfg_q.rrd_code <= RRD_RST;
      cfg_q.mrd_code <= MRD_RST;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        SEL_REF: cfg_q.ref_code <= wdata[REF_W-1:0];
        SEL_SRX: cfg_q.srx_code <= wdata[SRX_W-1:0];
        SEL_RRD: cfg_q.rrd_code <= wdata[RRD_W-1:0];
        SEL_MRD: cfg_q.mrd_code <= wdata[MRD_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      SEL_REF: rdata = DATA_W'(cfg_q.ref_code);
      SEL_SRX: rdata = DATA_W'(cfg_q.srx_code);
      SEL_RRD: rdata = DATA_W'(cfg_q.rrd_code);
      SEL_MRD: rdata = DATA_W'(cfg_q.mrd_code);
      default: rdata = '0;
    endcase
  end

  assign cfg = cfg_q;

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (cfg_q.ref_code == $past(wdata[REF_W-1:0]))); // R2
endmodule

// File: rtl/sdt_interval_ctr.sv
module sdt_interval_ctr #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic [CODE_W-1:0] code,
  output logic              idle
);
  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (trigger)
      count <= {1'b0, code} + CNT_W'(1);
    else if (count != '0)
      count <= count - CNT_W'(1);
  end

  assign idle = (count == '0);

  AST_LOAD_CODE_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (count == ({1'b0, $past(code)} + CNT_W'(1)))); // R6
  AST_STEADY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R9
endmodule

// File: rtl/sdt_bank_track.sv
module sdt_bank_track #(
  parameter int NUM_BANKS = 4,
  parameter int CODE_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act,
  input  logic [$clog2(NUM_BANKS)-1:0] act_bank,
  input  logic [CODE_W-1:0]            rrd_code,
  output logic [NUM_BANKS-1:0]         bank_ok
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic              rrd_idle;
  logic [BANK_W-1:0] last_bank;

  sdt_interval_ctr #(.CODE_W(CODE_W)) u_rrd_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (act),
    .code    (rrd_code),
    .idle    (rrd_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_bank <= '0;
    else if (act)
      last_bank <= act_bank;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_ok[g] = rrd_idle || (last_bank == BANK_W'(g));
  end

  AST_SAME_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> bank_ok[$past(act_bank)]); // R7
endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 cmd_refresh,
  input  logic                 cmd_sr_exit,
  input  logic                 cmd_mode_load,
  input  logic                 cmd_act,
  input  logic [BANK_W-1:0]    cmd_act_bank,
  output logic [NUM_BANKS-1:0] act_allowed
);
  timing_cfg_t          cfg;
  logic                 ref_idle, srx_idle, mrd_idle;
  logic                 events_clear;
  logic [NUM_BANKS-1:0] bank_ok;

  sdt_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  sdt_interval_ctr #(.CODE_W(REF_W)) u_ref_ctr (
    .clk (clk), .rst_n (rst_n), .trigger (cmd_refresh),
    .code (cfg.ref_code), .idle (ref_idle)
  );

  sdt_interval_ctr #(.CODE_W(SRX_W)) u_srx_ctr (
    .clk (clk), .rst_n (rst_n), .trigger (cmd_sr_exit),
    .code (cfg.srx_code), .idle (srx_idle)
  );

  sdt_interval_ctr #(.CODE_W(MRD_W)) u_mrd_ctr (
    .clk (clk), .rst_n (rst_n), .trigger (cmd_mode_load),
    .code (cfg.mrd_code), .idle (mrd_idle)
  );

  sdt_bank_track #(.NUM_BANKS(NUM_BANKS), .CODE_W(RRD_W)) u_bank_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (cmd_act),
    .act_bank (cmd_act_bank),
    .rrd_code (cfg.rrd_code),
    .bank_ok  (bank_ok)
  );

  assign events_clear = ref_idle && srx_idle && mrd_idle;
  assign act_allowed  = {NUM_BANKS{events_clear}} & bank_ok;

  AST_REFRESH_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |=> (act_allowed == '0)); // R3
  AST_SR_EXIT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sr_exit |=> (act_allowed == '0)); // R4
  AST_MODE_LOAD_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mode_load |=> (act_allowed == '0)); // R5
  AST_OTHER_BANKS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> ((act_allowed & ~(NUM_BANKS'(1) << $past(cmd_act_bank))) == '0)); // R7
endmodule

// File: tb/sdram_cmd_spacer_bench.sv
module sdram_cmd_spacer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_refresh = 1'b0, cmd_sr_exit = 1'b0, cmd_mode_load = 1'b0, cmd_act = 1'b0;
  logic [1:0]  cmd_act_bank = '0;
  logic [3:0]  act_allowed;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sdram_cmd_spacer u_sdram_cmd_spacer (
    .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .cmd_refresh (cmd_refresh),
    .cmd_sr_exit (cmd_sr_exit), .cmd_mode_load (cmd_mode_load), .cmd_act (cmd_act),
    .cmd_act_bank (cmd_act_bank), .act_allowed (act_allowed)
  );

  // vector table: kind (0 refresh, 1 sr exit, 2 mode load, 3 activate), code, expected blocked cycles
  localparam int NV = 9;
  localparam int VKIND [NV] = '{0, 0, 0, 1, 1, 2, 2, 3, 3};
  localparam int VCODE [NV] = '{0, 7, 31, 9, 31, 0, 15, 15, 3};
  localparam int VEXP  [NV] = '{1, 8, 32, 10, 32, 1, 16, 16, 4};

  function automatic string vtag(int i);
    case (i)
      2, 4, 6, 7: vtag = "R6";
      3:          vtag = "R4";
      5:          vtag = "R5";
      8:          vtag = "R7";
      default:    vtag = "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  // raise the selected strobes for one cycle; returns at the negedge after the loading edge
  task automatic pulse(input bit r, input bit s, input bit m, input bit a, input int bank);
    @(negedge clk);
    cmd_refresh = r; cmd_sr_exit = s; cmd_mode_load = m; cmd_act = a; cmd_act_bank = 2'(bank);
    @(negedge clk);
    cmd_refresh = 0; cmd_sr_exit = 0; cmd_mode_load = 0; cmd_act = 0;
  endtask

  task automatic measure(input int b, output int len);
    len = 0;
    while (!act_allowed[b] && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: all banks allowed out of reset
    @(negedge clk);
    check(act_allowed == 4'hF, "R8", act_allowed, 15);
    // R1: reset values
    rd(0, d); check(d == 7, "R1", d, 7);
    rd(1, d); check(d == 9, "R1", d, 9);
    rd(2, d); check(d == 1, "R1", d, 1);
    rd(3, d); check(d == 0, "R1", d, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      int reg_a;
      case (VKIND[i]) 0: reg_a = 0; 1: reg_a = 1; 2: reg_a = 3; default: reg_a = 2; endcase
      wr(reg_a, 32'(VCODE[i]));
      pulse(VKIND[i] == 0, VKIND[i] == 1, VKIND[i] == 2, VKIND[i] == 3, 0);
      if (VKIND[i] == 3) begin
        check(act_allowed[0] == 1'b1, "R7", act_allowed[0], 1);
        measure(1, len);
      end else begin
        measure(0, len);
      end
      check(len == VEXP[i], vtag(i), len, VEXP[i]);
      settle();
    end

    // R2: reserved bits ignored and read as zero
    wr(0, 32'hFFFF_FFFF); rd(0, d); check(d == 32'h1F, "R2", d, 32'h1F);
    wr(2, 32'hFFFF_FFF0); rd(2, d); check(d == 32'h0, "R2", d, 0);
    wr(3, 32'hA5A5_A5A6); rd(3, d); check(d == 32'h6, "R2", d, 6);

    // R7: same bank allowed, other banks blocked after activate to bank 2
    wr(2, 32'd5);
    pulse(0, 0, 0, 1, 2);
    check(act_allowed == 4'b0100, "R7", act_allowed, 4);
    measure(3, len);
    check(len == 6, "R7", len, 6);
    settle();

    // R8: overlapping intervals, the longer one releases
    wr(0, 32'd4); wr(3, 32'd9);
    pulse(1, 0, 1, 0, 0);
    measure(2, len);
    check(len == 10, "R8", len, 10);
    settle();
    wr(0, 32'd20); wr(1, 32'd2);
    pulse(1, 1, 0, 0, 0);
    measure(1, len);
    check(len == 21, "R8", len, 21);
    settle();

    // R9: rewrite during a count leaves it unchanged
    wr(0, 32'd19);
    pulse(1, 0, 0, 0, 0);
    len = 0;
    while (!act_allowed[0] && len < 100) begin
      len++;
      if (len == 3) begin reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd2; end
      if (len == 4) reg_wr_en = 1'b0;
      @(negedge clk);
    end
    reg_wr_en = 1'b0;
    check(len == 20, "R9", len, 20);
    settle();
    pulse(1, 0, 0, 0, 0);
    measure(0, len);
    check(len == 3, "R9", len, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule